// File: doc/BRIEF.md
# Transmit Collision and Deferral Status Accounting

This block follows one outgoing frame from its first attempt to its final outcome. It builds the status field that the transmit engine writes back into the frame's descriptor. A start strobe opens each frame and clears everything. After that, the block counts collisions, one pulse per failed attempt, and times how long the frame waited on a deferral. It also holds the failure indications raised by the datapath: abort, FIFO underrun, carrier lost and late collision. When a frame finishes, it folds all of this into a single good/bad verdict.

After every collision the block returns a decision. Either it asks for another attempt with a one-cycle retry strobe, or it holds a give-up level once the collision limit is reached. A retry-mode bit sets that limit. With the bit at 0, the limit is 16 collisions and the 4-bit collision field is a plain count. With the bit at 1, the limit is 64 collisions. The field then splits into a count of completed 16-collision blocks plus single/multiple flags for the remainder. The mode bit is captured at the start strobe. The deferral threshold is 3.2 ms, converted to cycles from a clock-frequency parameter.

Top module: `tx_coll_status`

## Requirements
- R1: The cycle after `start_i` is sampled, every status bit reads 0. Events presented in the same cycle as `start_i` are discarded.
- R2: With the retry mode captured as 0, `stat_o[19:16]` equals the number of collisions modulo 16. After the 16th collision, `stat_o[20]` (excessive collisions) is 1 and further collisions change nothing.
- R3: With the retry mode captured as 1, `stat_o[19:18]` holds the number of whole 16-collision blocks. Taking r as the collision count modulo 16, `stat_o[16]` is 1 when r equals 1 and `stat_o[17]` is 1 when r is 2 or more. For example, 33 collisions gives 4'b1001 and 34 gives 4'b1010.
- R4: With the retry mode captured as 1, `stat_o[20]` sets only at the 64th collision. At that point `stat_o[19:16]` reads 0.
- R5: A collision that leaves the count below the active limit gives a one-cycle `retry_o` pulse in the following cycle. The collision that reaches the limit gives no retry pulse and raises `give_up_o`. `give_up_o` stays high until the next start, and `retry_o` is never high while `give_up_o` is high.
- R6: `stat_o[23]` (deferred) is 1 once `defer_i` has been sampled high for at least one cycle of the frame.
- R7: `stat_o[22]` (excessive deferral) becomes 1 once `defer_i` has been sampled high on more than the 3.2 ms cycle limit, counted cumulatively over the frame. With `CLK_HZ` = 1 MHz the limit is 3200 cycles, so the bit sets on the 3201st sampled cycle.
- R8: A `crs_lost_i` pulse sets `stat_o[24]` only when `crs_ign_i` is 0 in that cycle. Otherwise bit 24 stays 0.
- R9: Pulses on `abort_i`, `underrun_i` and `owc_i` set `stat_o[26]`, `stat_o[25]` and `stat_o[21]` respectively. Each bit holds until the next start.
- R10: `stat_o[27]` (frame OK) is 1 only when all of these hold: `done_i` has been seen since start, `last_desc_i` is 1, and none of bits 26, 25, 22 or 20 is set.
- R11: `stat_o` bits 31:28 and 15:0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New-frame strobe; clears all status and captures the mode |
| coll_i | input | 1 | One pulse per collision (failed attempt) |
| owc_i | input | 1 | Out-of-window collision seen |
| defer_i | input | 1 | High while transmission is being deferred |
| abort_i | input | 1 | Transmission aborted |
| underrun_i | input | 1 | Transmit FIFO ran dry |
| crs_lost_i | input | 1 | Carrier dropped during transmission |
| ext_retry_i | input | 1 | Retry mode: 0 = 16-collision limit, 1 = 64-collision limit with split field |
| crs_ign_i | input | 1 | Suppress carrier-lost reporting |
| done_i | input | 1 | Frame transmission finished |
| last_desc_i | input | 1 | Status is being written to the frame's final descriptor |
| stat_o | output | 32 | Descriptor status word (bits 27:16 used) |
| retry_o | output | 1 | One-cycle request for another attempt |
| give_up_o | output | 1 | Collision limit reached; no further attempts |

## Verification
A wrong collision count would show at the ports in the very next cycle, as a bad value on bits 19:16. It would show again at the limit, when the retry pulse fails to stop or `give_up_o` rises at the wrong collision. The mode decode is therefore checked at counts on both sides of each block boundary. The deferral timer is wide, so an off-by-one there shows only at the threshold: bit 22 must read 0 after exactly the limit and 1 one cycle later. A mode latched at the wrong moment, or a sticky flag that fails to clear, shows up on the first status read of the following frame.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
   // Status word bit positions: fixed by the descriptor layout the driver decodes.
   localparam int unsigned B_OK      = 27;
   localparam int unsigned B_ABORT   = 26;
   localparam int unsigned B_UNDR    = 25;
   localparam int unsigned B_CRS     = 24;
   localparam int unsigned B_DEF     = 23;
   localparam int unsigned B_EXDEF   = 22;
   localparam int unsigned B_OWC     = 21;
   localparam int unsigned B_EXCOL   = 20;
   localparam int unsigned B_CCNT_LO = 16;

   // Sticky event flags held in the flag bank.
   typedef enum int unsigned {
      F_ABORT = 0,
      F_UNDR  = 1,
      F_CRS   = 2,
      F_OWC   = 3,
      F_DONE  = 4
   } flag_idx_e;
   localparam int unsigned NUM_FLAGS = 5;
endpackage

// File: rtl/txcs_flag_bank.sv
module txcs_flag_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("txcs_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (clr_i)    q_o[i] <= 1'b0;
         else if (set_i[i]) q_o[i] <= 1'b1;
      end

      // R9: a set flag stays set until the next clear
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[i] && !clr_i) |=> q_o[i]);
   end
endmodule

// File: rtl/txcs_coll_count.sv
module txcs_coll_count #(
   parameter int unsigned BASE_LIMIT = 16,
   parameter int unsigned EXT_BLOCKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       mode_i,
   input  logic       coll_i,
   output logic [3:0] field_o,
   output logic       excess_o,
   output logic       retry_o
);
   localparam int unsigned EXT_LIMIT = BASE_LIMIT * EXT_BLOCKS;
   localparam int unsigned CW        = $clog2(EXT_LIMIT + 1);
   localparam int unsigned RW        = $clog2(BASE_LIMIT);

   if (BASE_LIMIT != 16) begin : g_bad_base
      $error("txcs_coll_count: the 4-bit field layout needs BASE_LIMIT of 16");
   end
   if (EXT_BLOCKS != 4) begin : g_bad_blocks
      $error("txcs_coll_count: a 2-bit block count needs EXT_BLOCKS of 4");
   end

   logic          mode_q;
   logic [CW-1:0] total_q;
   logic [CW-1:0] limit;
   logic [CW-1:0] total_nx;
   logic [RW-1:0] rem;
   logic [1:0]    blocks;

   always_comb begin
      limit    = mode_q ? CW'(EXT_LIMIT) : CW'(BASE_LIMIT);
      excess_o = (total_q >= limit);
      total_nx = total_q + CW'(1);
      rem      = total_q[RW-1:0];
      blocks   = total_q[RW+1:RW];
      if (mode_q)
         field_o = {blocks, (rem >= RW'(2)), (rem == RW'(1))};
      else
         field_o = total_q[3:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         total_q <= '0;
         retry_o <= 1'b0;
      end else if (start_i) begin
         mode_q  <= mode_i;
         total_q <= '0;
         retry_o <= 1'b0;
      end else begin
         retry_o <= coll_i && !excess_o && (total_nx < limit);
         if (coll_i && !excess_o) total_q <= total_nx;
      end
   end

   // R2: the count never passes the active limit
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      total_q <= limit);
   // R2: each collision below the limit adds exactly one
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_i && !excess_o && !start_i) |=> (total_q == $past(total_q) + CW'(1)));
   // R5: no retry once the limit has been reached
   p_retry_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      excess_o |-> !retry_o);
endmodule

// File: rtl/txcs_defer_timer.sv
module txcs_defer_timer #(
   parameter int unsigned CLK_HZ         = 100_000_000,
   parameter int unsigned LIMIT_TENTH_MS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic defer_i,
   output logic deferred_o,
   output logic excess_o
);
   localparam int unsigned CYC_PER_TENTH = CLK_HZ / 10_000;
   localparam int unsigned LIMIT_CYC     = CYC_PER_TENTH * LIMIT_TENTH_MS;
   localparam int unsigned SAT           = LIMIT_CYC + 1;
   localparam int unsigned TW            = $clog2(SAT + 1);

   if (CLK_HZ < 10_000) begin : g_bad_clk
      $error("txcs_defer_timer: CLK_HZ must be at least 10 kHz");
   end
   if (LIMIT_TENTH_MS == 0) begin : g_bad_lim
      $error("txcs_defer_timer: LIMIT_TENTH_MS must be non-zero");
   end

   logic [TW-1:0] cnt_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (defer_i) begin
         seen_q <= 1'b1;
         if (cnt_q != TW'(SAT)) cnt_q <= cnt_q + TW'(1);
      end
   end

   assign deferred_o = seen_q;
   assign excess_o   = (cnt_q == TW'(SAT));

   // R7: the timer saturates one step past the limit
   p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TW'(SAT));
   // R6: excessive deferral is never reported without the deferred flag
   p_ex_has_def_r6: assert property (@(posedge clk) disable iff (!rst_n)
      excess_o |-> deferred_o);
endmodule

// File: rtl/tx_coll_status.sv
module tx_coll_status
   import txcs_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 100_000_000,
   parameter int unsigned LIMIT_TENTH_MS = 32,
   parameter int unsigned BASE_LIMIT     = 16,
   parameter int unsigned EXT_BLOCKS     = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        coll_i,
   input  logic        owc_i,
   input  logic        defer_i,
   input  logic        abort_i,
   input  logic        underrun_i,
   input  logic        crs_lost_i,
   input  logic        ext_retry_i,
   input  logic        crs_ign_i,
   input  logic        done_i,
   input  logic        last_desc_i,
   output logic [31:0] stat_o,
   output logic        retry_o,
   output logic        give_up_o
);
   logic [NUM_FLAGS-1:0] fset;
   logic [NUM_FLAGS-1:0] flg;
   logic [3:0]           ccnt;
   logic                 excol;
   logic                 deferred;
   logic                 exdef;
   logic                 frame_ok;

   always_comb begin
      fset          = '0;
      fset[F_ABORT] = abort_i;
      fset[F_UNDR]  = underrun_i;
      fset[F_CRS]   = crs_lost_i && !crs_ign_i;
      fset[F_OWC]   = owc_i;
      fset[F_DONE]  = done_i;
   end

   txcs_flag_bank #(.N(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_i),
      .set_i (fset),
      .q_o   (flg)
   );

   txcs_coll_count #(.BASE_LIMIT(BASE_LIMIT), .EXT_BLOCKS(EXT_BLOCKS)) u_coll (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mode_i   (ext_retry_i),
      .coll_i   (coll_i),
      .field_o  (ccnt),
      .excess_o (excol),
      .retry_o  (retry_o)
   );

   txcs_defer_timer #(.CLK_HZ(CLK_HZ), .LIMIT_TENTH_MS(LIMIT_TENTH_MS)) u_defer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .defer_i    (defer_i),
      .deferred_o (deferred),
      .excess_o   (exdef)
   );

   assign frame_ok  = flg[F_DONE] && last_desc_i && !flg[F_ABORT] && !flg[F_UNDR]
                      && !excol && !exdef;
   assign give_up_o = excol;

   always_comb begin
      stat_o                        = '0;
      stat_o[B_OK]                  = frame_ok;
      stat_o[B_ABORT]               = flg[F_ABORT];
      stat_o[B_UNDR]                = flg[F_UNDR];
      stat_o[B_CRS]                 = flg[F_CRS];
      stat_o[B_DEF]                 = deferred;
      stat_o[B_EXDEF]               = exdef;
      stat_o[B_OWC]                 = flg[F_OWC];
      stat_o[B_EXCOL]               = excol;
      stat_o[B_CCNT_LO+3:B_CCNT_LO] = ccnt;
   end

   // R1: a start leaves a fully cleared status word behind it
   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (stat_o == 32'h0 && !retry_o && !give_up_o));
   // R10: frame OK never coexists with a failure bit
   p_ok_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[B_OK] |-> !(stat_o[B_ABORT] || stat_o[B_UNDR] || stat_o[B_EXDEF] || stat_o[B_EXCOL]));
   // R11: unused bits stay zero
   p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[31:28] == 4'h0) && (stat_o[15:0] == 16'h0));
   // R8: carrier loss raised while suppressed does not newly set the bit
   p_crs_ign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (crs_ign_i && !stat_o[B_CRS] && !start_i) |=> !stat_o[B_CRS]);
endmodule

// File: tb/tx_coll_status_tb_top.sv
module tx_coll_status_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 0, coll_i = 0, owc_i = 0, defer_i = 0, abort_i = 0;
   logic        underrun_i = 0, crs_lost_i = 0, ext_retry_i = 0, crs_ign_i = 0;
   logic        done_i = 0, last_desc_i = 0;
   logic [31:0] stat_o;
   logic        retry_o, give_up_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   localparam int unsigned DEF_LIM = 3200; // 1 MHz * 3.2 ms

   always #5 clk = ~clk;

   tx_coll_status #(.CLK_HZ(1_000_000)) dut_i (.*);

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic new_frame(input logic mode);
      @(negedge clk);
      ext_retry_i = mode; start_i = 1;
      @(negedge clk);
      start_i = 0; ext_retry_i = 0;
   endtask

   // one collision; returns retry_o as seen the cycle after
   task automatic collide(output logic rt);
      @(negedge clk); coll_i = 1;
      @(negedge clk); coll_i = 0; rt = retry_o;
   endtask

   task automatic collide_n(input int n);
      logic rt;
      for (int i = 0; i < n; i++) collide(rt);
   endtask

   task automatic t_reset;
      check("R1", "reset status", stat_o, 32'h0);
      check("R5", "reset retry/giveup", {30'h0, retry_o, give_up_o}, 32'h0);
   endtask

   task automatic t_mode0;
      logic rt;
      new_frame(1'b0);
      collide(rt);
      check("R5", "retry after first collision", {31'h0, rt}, 32'h1);
      @(negedge clk);
      check("R5", "retry is one cycle", {31'h0, retry_o}, 32'h0);
      collide_n(4);
      check("R2", "count after 5", {28'h0, stat_o[19:16]}, 32'h5);
      collide_n(10);
      check("R2", "count after 15", {28'h0, stat_o[19:16]}, 32'hF);
      check("R2", "no excess at 15", {31'h0, stat_o[20]}, 32'h0);
      collide(rt);
      check("R5", "no retry at 16th", {31'h0, rt}, 32'h0);
      check("R2", "excess at 16", {31'h0, stat_o[20]}, 32'h1);
      check("R5", "give up at 16", {31'h0, give_up_o}, 32'h1);
      collide(rt);
      check("R2", "frozen after limit", {27'h0, stat_o[20:16]}, 32'h10);
      check("R5", "no retry after give up", {31'h0, rt}, 32'h0);
   endtask

   task automatic t_mode1;
      logic rt;
      new_frame(1'b1);
      collide_n(1);
      check("R3", "ext 1 collision", {28'h0, stat_o[19:16]}, 32'h1);
      collide_n(1);
      check("R3", "ext 2 collisions", {28'h0, stat_o[19:16]}, 32'h2);
      collide_n(14);
      check("R3", "ext 16 collisions", {27'h0, stat_o[20:16]}, 32'h4);
      check("R4", "no give up at 16 ext", {31'h0, give_up_o}, 32'h0);
      collide_n(17);
      check("R3", "ext 33 collisions", {28'h0, stat_o[19:16]}, 32'h9);
      collide_n(1);
      check("R3", "ext 34 collisions", {28'h0, stat_o[19:16]}, 32'hA);
      collide_n(29);
      check("R3", "ext 63 collisions", {27'h0, stat_o[20:16]}, 32'h0E);
      collide(rt);
      check("R4", "ext 64 excess, field 0", {27'h0, stat_o[20:16]}, 32'h10);
      check("R5", "ext no retry at 64", {30'h0, rt, give_up_o}, 32'h1);
      new_frame(1'b0);
      check("R1", "clear after ext frame", stat_o, 32'h0);
      collide_n(2);
      check("R2", "mode recaptured as 0", {28'h0, stat_o[19:16]}, 32'h2);
   endtask

   task automatic t_defer;
      new_frame(1'b0);
      @(negedge clk); defer_i = 1;
      repeat (10) @(negedge clk);
      defer_i = 0;
      check("R6", "deferred set", {31'h0, stat_o[23]}, 32'h1);
      check("R7", "short defer not excessive", {31'h0, stat_o[22]}, 32'h0);
      defer_i = 1;
      repeat (DEF_LIM - 10) @(negedge clk);
      defer_i = 0;
      check("R7", "exactly limit not excessive", {31'h0, stat_o[22]}, 32'h0);
      repeat (5) @(negedge clk);
      defer_i = 1;
      @(negedge clk); defer_i = 0;
      check("R7", "limit+1 excessive", {31'h0, stat_o[22]}, 32'h1);
      last_desc_i = 1; done_i = 1;
      @(negedge clk); done_i = 0;
      check("R10", "no OK with excess defer", {31'h0, stat_o[27]}, 32'h0);
      last_desc_i = 0;
   endtask

   task automatic t_flags;
      new_frame(1'b0);
      crs_ign_i = 1; crs_lost_i = 1;
      @(negedge clk); crs_lost_i = 0; crs_ign_i = 0;
      check("R8", "carrier loss ignored", {31'h0, stat_o[24]}, 32'h0);
      crs_lost_i = 1;
      @(negedge clk); crs_lost_i = 0;
      check("R8", "carrier loss reported", {31'h0, stat_o[24]}, 32'h1);
      abort_i = 1;
      @(negedge clk); abort_i = 0; underrun_i = 1;
      @(negedge clk); underrun_i = 0; owc_i = 1;
      @(negedge clk); owc_i = 0;
      repeat (3) @(negedge clk);
      check("R9", "abort/underrun/owc held", {29'h0, stat_o[26], stat_o[25], stat_o[21]}, 32'h7);
      check("R11", "unused bits zero", stat_o & 32'hF000_FFFF, 32'h0);
      // start with a simultaneous event: event dropped
      start_i = 1; abort_i = 1;
      @(negedge clk); start_i = 0; abort_i = 0;
      check("R1", "start wins over same-cycle abort", stat_o, 32'h0);
   endtask

   task automatic t_ok;
      new_frame(1'b0);
      collide_n(3);
      done_i = 1;
      @(negedge clk); done_i = 0;
      check("R10", "not final descriptor", {31'h0, stat_o[27]}, 32'h0);
      last_desc_i = 1;
      #1;
      check("R10", "final descriptor OK", {31'h0, stat_o[27]}, 32'h1);
      check("R11", "word with OK", stat_o, 32'h0803_0000);
      abort_i = 1;
      @(negedge clk); abort_i = 0;
      check("R10", "abort kills OK", {31'h0, stat_o[27]}, 32'h0);
      new_frame(1'b0);
      check("R1", "OK cleared by start", {31'h0, stat_o[27]}, 32'h0);
      last_desc_i = 0;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_mode0();
      t_mode1();
      t_defer();
      t_flags();
      t_ok();
      finish_run();
   end

   initial begin
      repeat (150_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule